// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds the programming state of one channel in a four-channel DMA controller, together with the operation register that all channels share. A bus master reaches five registers through a small memory-mapped port: source address, destination address, a 24-bit transfer count, channel control, and the 16-bit shared operation register. The port accepts 16-bit and 32-bit accesses. A 16-bit write changes only the half-word it addresses. Status flags cannot be cleared by a blind write. Software must first read the flag as 1 and then write 0 to that bit.

A transfer engine outside this block reads the current address and count values from plain output pins. It advances them with single-cycle strobes: step the source address, step the destination address, or decrement the count. The address step is 2 or 4 bytes. Hardware events raise the status flags through dedicated set inputs.

The bus port uses valid/ready. The requester raises `req_valid` and holds every request field stable until it sees `req_ready`. The access takes effect on the clock edge where both are high. `req_ready` never rises in the first cycle of a request. It rises after a fixed latency: 3 cycles for a 16-bit access and 6 cycles for a 32-bit access. The block never applies back-pressure beyond that fixed latency. Read data and the error flag are valid only while `req_ready` is high.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the source address, destination address, transfer count, channel control and operation register all read as zero.
- R2: `req_ready` is high only while `req_valid` is high. It first rises in cycle 3 of a held 16-bit request (`req_wide`=0) and in cycle 6 of a held 32-bit request (`req_wide`=1), counting the first cycle in which valid is high as cycle 1.
- R3: Register byte offsets are 0xF0 (source), 0xF4 (destination), 0xF8 (count), 0xFC (control) and 0xB0 (operation). For the 32-bit registers, a 16-bit access at offset+0 selects bits 31:16 and an access at offset+2 selects bits 15:0. A 16-bit read returns the selected half in `rsp_rdata[15:0]`, with the upper 16 bits zero.
- R4: A 16-bit write to the source, destination or control register leaves the other half-word unchanged.
- R5: The count register holds 24 bits. Write data in bits 31:24 is ignored, and those bits always read as 0. A 16-bit access at 0xF8 carries count bits 23:16 in data bits 7:0.
- R6: The operation register accepts only a 16-bit access at 0xB0. Any of the following completes with `rsp_err`=1 and `rsp_rdata`=0 and changes no register: a 32-bit access to 0xB0, an access to 0xB2, an unmapped offset, or a misaligned access.
- R7: Control bit 1 and operation bits 1 and 2 are status flags. Writing 1 to a flag has no effect. Writing 0 clears a flag only if an earlier read returned that flag as 1. All other bits are ordinary read/write bits.
- R8: A hardware set of a flag in the same cycle as a software clear leaves the flag at 1. Every hardware set cancels any earlier read, so a new read of 1 is needed before a clear.
- R9: `step_src` and `step_dst` add 2 (`step_wide`=0) or 4 (`step_wide`=1) to their address. `dec_count` subtracts 1 from the count and holds it at 0 once it reaches 0.
- R10: A bus write to a register in the same cycle as an engine strobe on that register stores the written value.
- R11: The outputs `src_addr`, `dst_addr`, `xfer_count`, `chan_ctrl` and `op_ctrl` show the current register contents, including the flag bits, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Access completes this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_addr | input | 8 | Byte offset within the block |
| req_wdata | input | 32 | Write data (16-bit data in bits 15:0) |
| rsp_rdata | output | 32 | Read data, valid with ready |
| rsp_err | output | 1 | Access rejected, valid with ready |
| step_src | input | 1 | Advance source address |
| step_dst | input | 1 | Advance destination address |
| step_wide | input | 1 | Step size: 0 = 2 bytes, 1 = 4 bytes |
| dec_count | input | 1 | Decrement transfer count |
| set_chan_flag | input | 1 | Hardware set of control flag bit 1 |
| set_op_flags | input | 2 | Hardware set of operation flag bits 2:1 |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| xfer_count | output | 24 | Current transfer count |
| chan_ctrl | output | 32 | Channel control register |
| op_ctrl | output | 16 | Shared operation register |

## Verification
The case that most needs checking is a hardware flag set arriving on the same clock edge as a software write of 0 that would otherwise clear the flag. The bench provokes it by raising `set_chan_flag` during the ready cycle of a clear-write that follows a valid read of 1. The flag must stay at 1. A second write of 0 with no new read must also leave it at 1. A similar collision, an engine source step during a bus write to the source register, is judged by the stored value matching the written data.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam logic [7:0] OFS_SRC = 8'hF0;
  localparam logic [7:0] OFS_DST = 8'hF4;
  localparam logic [7:0] OFS_CNT = 8'hF8;
  localparam logic [7:0] OFS_CTL = 8'hFC;
  localparam logic [7:0] OFS_OPR = 8'hB0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SRC, SEL_DST, SEL_CNT, SEL_CTL, SEL_OPR
  } reg_sel_e;

  // Merge bus write data into a 32-bit register image.
  // hi=1 selects bits 31:16 for a 16-bit write.
  function automatic logic [31:0] merge_word(input logic [31:0] old_v,
                                             input logic [31:0] wdata,
                                             input logic        wide,
                                             input logic        hi);
    if (wide)    return wdata;
    else if (hi) return {wdata[15:0], old_v[15:0]};
    else         return {old_v[31:16], wdata[15:0]};
  endfunction

endpackage

// File: rtl/bus_latency_gate.sv
module bus_latency_gate #(
  parameter int LAT_HALF = 3,
  parameter int LAT_FULL = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic wide,
  output logic ready
);
  localparam int CW = $clog2(LAT_FULL + 1);

  logic [CW-1:0] wait_q;
  logic [CW-1:0] target;

  assign target = wide ? CW'(LAT_FULL - 1) : CW'(LAT_HALF - 1);
  assign ready  = valid && (wait_q == target);

  always_ff @(posedge clk) begin
    if (!rst_n)             wait_q <= '0;
    else if (!valid || ready) wait_q <= '0;
    else                    wait_q <= wait_q + 1'b1;
  end

  AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> valid); // R2
  AST_NO_READY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> !ready); // R2

endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int  WIDTH = 32,
  parameter int  AMT_W = 3,
  parameter bit  DOWN  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  input  logic [AMT_W-1:0] step_amt,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] val_q;
  logic [WIDTH-1:0] stepped;

  generate
    if (DOWN) begin : g_down
      assign stepped = (val_q == '0) ? '0 : val_q - WIDTH'(step_amt);
    end else begin : g_up
      assign stepped = val_q + WIDTH'(step_amt);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     val_q <= '0;
    else if (load)  val_q <= load_val;
    else if (step)  val_q <= stepped;
  end

  assign value = val_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> value == $past(load_val)); // R10

endmodule

// File: rtl/rc_flag.sv
module rc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (hw_set) begin
      flag_q <= 1'b1;
      seen_q <= 1'b0;
    end else if (wr_hit && !wr_bit && seen_q) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (rd_hit && flag_q) begin
      seen_q <= 1'b1;
    end
  end

  assign flag = flag_q;

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag); // R8
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_hit && !wr_bit)) |=> flag); // R7
  AST_CLEAR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(seen_q)); // R7

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int LAT_HALF    = 3,
  parameter int LAT_FULL    = 6,
  parameter int CNT_W       = 24,
  parameter int OPR_W       = 16,
  parameter int CH_FLAG_BIT = 1,
  parameter int OP_FLAG_LO  = 1,
  parameter int N_OP_FLAGS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_wide,
  input  logic [7:0]            req_addr,
  input  logic [31:0]           req_wdata,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  input  logic                  step_src,
  input  logic                  step_dst,
  input  logic                  step_wide,
  input  logic                  dec_count,
  input  logic                  set_chan_flag,
  input  logic [N_OP_FLAGS-1:0] set_op_flags,
  output logic [31:0]           src_addr,
  output logic [31:0]           dst_addr,
  output logic [CNT_W-1:0]      xfer_count,
  output logic [31:0]           chan_ctrl,
  output logic [OPR_W-1:0]      op_ctrl
);
  localparam int DW = 32;
  localparam logic [DW-1:0]    CTL_FLAG_MASK = DW'(1) << CH_FLAG_BIT;
  localparam logic [OPR_W-1:0] OPR_FLAG_MASK =
    OPR_W'(((1 << N_OP_FLAGS) - 1) << OP_FLAG_LO);

  reg_sel_e      sel;
  logic          misalign, opr_bad, dec_err, hi;
  logic          acc, wr_ok, rd_ok;
  logic [DW-1:0] cur_word, merged;
  logic [2:0]    addr_step;
  logic          ch_flag;
  logic [N_OP_FLAGS-1:0] op_flags;
  logic [DW-1:0]    ctl_q;
  logic [OPR_W-1:0] opr_q;
  logic          ch_cover;

  // Address decode
  always_comb begin
    case ({req_addr[7:2], 2'b00})
      OFS_SRC: sel = SEL_SRC;
      OFS_DST: sel = SEL_DST;
      OFS_CNT: sel = SEL_CNT;
      OFS_CTL: sel = SEL_CTL;
      OFS_OPR: sel = SEL_OPR;
      default: sel = SEL_NONE;
    endcase
  end

  assign misalign = req_wide ? (req_addr[1:0] != 2'b00) : req_addr[0];
  assign opr_bad  = (sel == SEL_OPR) && (req_wide || req_addr[1]);
  assign dec_err  = (sel == SEL_NONE) || misalign || opr_bad;
  assign hi       = !req_wide && !req_addr[1] && (sel != SEL_OPR);

  bus_latency_gate #(.LAT_HALF(LAT_HALF), .LAT_FULL(LAT_FULL)) u_gate (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .wide(req_wide),
    .ready(req_ready)
  );

  assign acc   = req_valid && req_ready;
  assign wr_ok = acc && req_write && !dec_err;
  assign rd_ok = acc && !req_write && !dec_err;

  always_comb begin
    case (sel)
      SEL_SRC: cur_word = src_addr;
      SEL_DST: cur_word = dst_addr;
      SEL_CNT: cur_word = DW'(xfer_count);
      SEL_CTL: cur_word = chan_ctrl;
      SEL_OPR: cur_word = DW'(op_ctrl);
      default: cur_word = '0;
    endcase
  end

  assign merged = merge_word(cur_word, req_wdata, req_wide, hi);

  always_comb begin
    if (!rd_ok)        rsp_rdata = '0;
    else if (req_wide) rsp_rdata = cur_word;
    else if (hi)       rsp_rdata = {16'h0000, cur_word[31:16]};
    else               rsp_rdata = {16'h0000, cur_word[15:0]};
  end
  assign rsp_err = acc && dec_err;

  // Address and count counters
  assign addr_step = step_wide ? 3'd4 : 3'd2;

  step_counter #(.WIDTH(DW), .AMT_W(3), .DOWN(1'b0)) u_src (
    .clk(clk), .rst_n(rst_n), .load(wr_ok && sel == SEL_SRC),
    .load_val(merged), .step(step_src), .step_amt(addr_step), .value(src_addr)
  );

  step_counter #(.WIDTH(DW), .AMT_W(3), .DOWN(1'b0)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(wr_ok && sel == SEL_DST),
    .load_val(merged), .step(step_dst), .step_amt(addr_step), .value(dst_addr)
  );

  logic cnt_load;
  assign cnt_load = wr_ok && sel == SEL_CNT;

  step_counter #(.WIDTH(CNT_W), .AMT_W(1), .DOWN(1'b1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load),
    .load_val(merged[CNT_W-1:0]), .step(dec_count), .step_amt(1'b1),
    .value(xfer_count)
  );

  // Control and operation registers (plain bits)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      opr_q <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_CTL) ctl_q <= merged & ~CTL_FLAG_MASK;
      if (sel == SEL_OPR) opr_q <= merged[OPR_W-1:0] & ~OPR_FLAG_MASK;
    end
  end

  // Flags
  assign ch_cover = (sel == SEL_CTL) && (req_wide || !hi);

  rc_flag u_ch_flag (
    .clk(clk), .rst_n(rst_n), .hw_set(set_chan_flag),
    .rd_hit(rd_ok && ch_cover), .wr_hit(wr_ok && ch_cover),
    .wr_bit(req_wdata[CH_FLAG_BIT]), .flag(ch_flag)
  );

  generate
    for (genvar i = 0; i < N_OP_FLAGS; i++) begin : g_op_flag
      rc_flag u_op_flag (
        .clk(clk), .rst_n(rst_n), .hw_set(set_op_flags[i]),
        .rd_hit(rd_ok && sel == SEL_OPR), .wr_hit(wr_ok && sel == SEL_OPR),
        .wr_bit(req_wdata[OP_FLAG_LO + i]), .flag(op_flags[i])
      );
    end
  endgenerate

  always_comb begin
    chan_ctrl = ctl_q;
    chan_ctrl[CH_FLAG_BIT] = ch_flag;
    op_ctrl = opr_q;
    op_ctrl[OP_FLAG_LO +: N_OP_FLAGS] = op_flags;
  end

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_count && xfer_count == '0 && !cnt_load) |=> xfer_count == '0); // R9
  AST_ERR_NO_OPR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_err && req_write && set_op_flags == '0) |=> $stable(op_ctrl)); // R6
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == '0); // R6

endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_wide = 0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic step_src = 0, step_dst = 0, step_wide = 0, dec_count = 0;
  logic set_chan_flag = 0;
  logic [1:0] set_op_flags = '0;
  logic [31:0] src_addr, dst_addr, chan_ctrl;
  logic [23:0] xfer_count;
  logic [15:0] op_ctrl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .step_src(step_src), .step_dst(step_dst), .step_wide(step_wide),
    .dec_count(dec_count), .set_chan_flag(set_chan_flag),
    .set_op_flags(set_op_flags), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_count(xfer_count), .chan_ctrl(chan_ctrl), .op_ctrl(op_ctrl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // side: 0 none, 1 hardware set of control flag, 2 source step, in the ready cycle
  task automatic bus(input logic w, input logic wide, input logic [7:0] a,
                     input logic [31:0] d, input int side,
                     output logic [31:0] rd, output logic er, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = w; req_wide = wide; req_addr = a; req_wdata = d;
    lat = 1;
    while (!req_ready) begin
      @(negedge clk);
      lat++;
    end
    if (side == 1) set_chan_flag = 1;
    if (side == 2) step_src = 1;
    rd = rsp_rdata; er = rsp_err;
    @(posedge clk);
    #1;
    req_valid = 0; set_chan_flag = 0; step_src = 0;
  endtask

  task automatic engine(input logic s, input logic dd, input logic w, input logic c);
    @(negedge clk);
    step_src = s; step_dst = dd; step_wide = w; dec_count = c;
    @(posedge clk);
    #1;
    step_src = 0; step_dst = 0; step_wide = 0; dec_count = 0;
    @(negedge clk);
  endtask

  task automatic flags(input logic ch, input logic [1:0] op);
    @(negedge clk);
    set_chan_flag = ch; set_op_flags = op;
    @(posedge clk);
    #1;
    set_chan_flag = 0; set_op_flags = '0;
    @(negedge clk);
  endtask

  // {write, wide, addr, wdata, expected rdata, expected err, requirement}
  localparam int NV = 23;
  localparam logic [82:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'hF0, 32'h12345678, 32'h00000000, 1'b0, 8'd3},  // R3
    {1'b0, 1'b1, 8'hF0, 32'h0,        32'h12345678, 1'b0, 8'd3},
    {1'b1, 1'b0, 8'hF0, 32'h0000ABCD, 32'h00000000, 1'b0, 8'd4},  // R4
    {1'b0, 1'b1, 8'hF0, 32'h0,        32'hABCD5678, 1'b0, 8'd4},
    {1'b1, 1'b0, 8'hF2, 32'h00001111, 32'h00000000, 1'b0, 8'd4},
    {1'b0, 1'b0, 8'hF0, 32'h0,        32'h0000ABCD, 1'b0, 8'd3},
    {1'b0, 1'b0, 8'hF2, 32'h0,        32'h00001111, 1'b0, 8'd3},
    {1'b1, 1'b1, 8'hF8, 32'hFF123456, 32'h00000000, 1'b0, 8'd5},  // R5
    {1'b0, 1'b1, 8'hF8, 32'h0,        32'h00123456, 1'b0, 8'd5},
    {1'b0, 1'b0, 8'hF8, 32'h0,        32'h00000012, 1'b0, 8'd5},
    {1'b1, 1'b0, 8'hF8, 32'h0000AB99, 32'h00000000, 1'b0, 8'd5},
    {1'b0, 1'b1, 8'hF8, 32'h0,        32'h00993456, 1'b0, 8'd5},
    {1'b1, 1'b1, 8'hB0, 32'hFFFFFFFF, 32'h00000000, 1'b1, 8'd6},  // R6
    {1'b0, 1'b0, 8'hB0, 32'h0,        32'h00000000, 1'b0, 8'd6},
    {1'b1, 1'b0, 8'hB0, 32'h0000F0FF, 32'h00000000, 1'b0, 8'd7},  // R7
    {1'b0, 1'b0, 8'hB0, 32'h0,        32'h0000F0F9, 1'b0, 8'd7},
    {1'b0, 1'b0, 8'hB2, 32'h0,        32'h00000000, 1'b1, 8'd6},
    {1'b1, 1'b1, 8'hFC, 32'h000000FF, 32'h00000000, 1'b0, 8'd7},
    {1'b0, 1'b1, 8'hFC, 32'h0,        32'h000000FD, 1'b0, 8'd7},
    {1'b0, 1'b0, 8'hFE, 32'h0,        32'h000000FD, 1'b0, 8'd3},
    {1'b0, 1'b1, 8'h40, 32'h0,        32'h00000000, 1'b1, 8'd6},
    {1'b1, 1'b0, 8'hF4, 32'h00001234, 32'h00000000, 1'b0, 8'd4},
    {1'b0, 1'b1, 8'hF4, 32'h0,        32'h12340000, 1'b0, 8'd4}
  };

  initial begin
    logic [31:0] rd;
    logic er;
    int lat;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 src", src_addr, 0);
    check("R1 dst", dst_addr, 0);
    check("R1 count", {8'h0, xfer_count}, 0);
    check("R1 ctrl", chan_ctrl, 0);
    check("R1 op", {16'h0, op_ctrl}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [82:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec %0d", v[7:0], i);
      bus(v[82], v[81], v[80:73], v[72:41], 0, rd, er, lat);
      check($sformatf("R2 latency vec %0d", i), lat, v[81] ? 6 : 3);
      check({tag, " err"}, {31'h0, er}, {31'h0, v[8]});
      if (!v[82]) check({tag, " rdata"}, rd, v[40:9]);
    end

    // Control flag rules
    flags(1'b1, 2'b00);
    check("R11 ctrl with flag", chan_ctrl, 32'h000000FF);
    bus(1, 1, 8'hFC, 32'h000000FD, 0, rd, er, lat);
    check("R7 clear without read ignored", chan_ctrl, 32'h000000FF);
    bus(0, 1, 8'hFC, 32'h0, 0, rd, er, lat);
    check("R7 read shows flag", rd, 32'h000000FF);
    bus(1, 1, 8'hFC, 32'h000000FD, 0, rd, er, lat);
    check("R7 clear after read", chan_ctrl, 32'h000000FD);
    flags(1'b1, 2'b00);
    bus(0, 1, 8'hFC, 32'h0, 0, rd, er, lat);
    bus(1, 1, 8'hFC, 32'h000000FD, 1, rd, er, lat);
    check("R8 set beats clear", chan_ctrl, 32'h000000FF);
    bus(1, 1, 8'hFC, 32'h000000FD, 0, rd, er, lat);
    check("R8 set re-arms read", chan_ctrl, 32'h000000FF);

    // Operation flags
    flags(1'b0, 2'b11);
    check("R11 op with flags", {16'h0, op_ctrl}, 32'h0000F0FF);
    bus(0, 0, 8'hB0, 32'h0, 0, rd, er, lat);
    check("R7 op read", rd, 32'h0000F0FF);
    bus(1, 0, 8'hB0, 32'h0000F0FD, 0, rd, er, lat);
    check("R7 op clear bit1 only", {16'h0, op_ctrl}, 32'h0000F0FD);

    // Engine strobes
    bus(1, 1, 8'hF0, 32'h00000100, 0, rd, er, lat);
    engine(1, 0, 0, 0);
    check("R9 src +2", src_addr, 32'h00000102);
    engine(1, 0, 1, 0);
    check("R9 src +4", src_addr, 32'h00000106);
    engine(0, 1, 1, 0);
    check("R9 dst +4", dst_addr, 32'h12340004);
    engine(0, 0, 0, 1);
    check("R9 count dec", {8'h0, xfer_count}, 32'h00993455);
    bus(1, 1, 8'hF8, 32'h00000001, 0, rd, er, lat);
    engine(0, 0, 0, 1);
    check("R9 count to zero", {8'h0, xfer_count}, 0);
    engine(0, 0, 0, 1);
    check("R9 count holds zero", {8'h0, xfer_count}, 0);
    bus(1, 1, 8'hF0, 32'h0000AAAA, 2, rd, er, lat);
    @(negedge clk);
    check("R10 write beats step", src_addr, 32'h0000AAAA);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule